// File: doc/BRIEF.md
# Indirect-Window Protection Register Bank

This block holds the per-entry settings of a supervisor-level physical memory protection unit. Each entry has one configuration word and one address word. Software does not reach these words directly. It first writes a select register to pick an entry. It then works through two alias data ports: one reaches the selected entry's address word and the other reaches its configuration word. Every access through an alias port is a CSR-style operation (read, write, set bits or clear bits). The response returns the value the word held before the operation.

Each configuration word is a full XLEN-wide register that belongs to a single entry. Only the permission bits, the two-bit match mode, the lock bit, the user bit and the shared bit are stored. All other bits are fixed at zero. An address word holds a physical address shifted right by two. It stores `ADDR_W` bits. When read back, it shows a coarse granularity in its low bits, so software can discover the granularity by writing all ones while the entry is OFF and reading the result.

A small state machine serialises the accesses. Its states are IDLE, ACCESS and RESP. IDLE moves to ACCESS when a request is accepted. ACCESS always moves to RESP; this is the cycle in which the old value is captured and the new value is committed. RESP always returns to IDLE; this is the cycle in which the response is presented. All entries' configuration and effective address values are driven out in parallel to an external checker. This block does no address matching and no access checking of its own.

Top module: `prot_reg_bank`

## Requirements
- R1: After reset every configuration word reads zero, so every entry is in OFF mode. Every address word is zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A select value from 0x100 to 0x13F picks entry (select − 0x100). Entry 0 is at 0x100 and entry 63 is at 0x13F. A write reaches only the selected entry.
- R3: `req_port` = 0 reaches the address word and `req_port` = 1 reaches the configuration word. `rsp_rdata` carries the word's value before the operation.
- R4: `req_op` encodes 00 = read (no change), 01 = write, 10 = set (old OR data) and 11 = clear (old AND NOT data). Set and clear act on the value as it reads back.
- R5: Configuration bits are mode-encoded as follows: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (00 OFF, 01 TOR, 10 NA4, 11 NAPOT), bit 7 lock, bit 8 user, bit 9 shared. Bits 6:5 and bits 10 and up ignore writes and read zero, so the writable mask is 0x39F.
- R6: An address word keeps the low `ADDR_W` (32) bits of the written data. Higher bits read zero.
- R7: With `GRAN` = 2, bits 1:0 of an address read zero in OFF, TOR and NA4 mode, and bit 0 reads one in NAPOT mode. Writing all ones with the entry OFF reads back 0xFFFFFFFC.
- R8: A select value outside 0x100–0x13F makes an access read zero, change no entry, and return `rsp_illegal` = 1. Legal accesses return `rsp_illegal` = 0.
- R9: Once an entry's lock bit (bit 7) is set, write, set and clear operations on that entry's configuration and address words are ignored until reset.
- R10: A request is accepted while `req_ready` is 1. `req_ready` is 0 during the next two cycles. `rsp_valid` is 1 for exactly one cycle, two clock edges after acceptance.
- R11: `cfg_all` holds entry i's configuration bits 9:0 at bits [10i+9:10i]. `addr_all` holds entry i's address as it reads back, at bits [32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | SEL_W (12) | New select value |
| sel_q | output | SEL_W (12) | Current select value |
| req_valid | input | 1 | Alias access request |
| req_ready | output | 1 | Bank is idle and can take a request |
| req_port | input | 1 | 0 = address alias, 1 = configuration alias |
| req_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| req_wdata | input | XLEN (64) | Operand for write, set or clear |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN (64) | Value before the operation |
| rsp_illegal | output | 1 | Select value was outside the window |
| cfg_all | output | NUM_ENTRIES*10 | All configuration words, in parallel |
| addr_all | output | NUM_ENTRIES*ADDR_W | All effective address words, in parallel |

## Verification
On every cycle, the assertions check the handshake shape: the bank is busy after an acceptance, a response follows the ACCESS state, and the response lasts one cycle. They also check that an out-of-window response carries zero data, that at most one entry write enable is active, that a locked entry's words never move, and that reserved configuration bits stay zero. Some behaviour can only be shown by the bench's scenarios, because it depends on specific values. This covers the value-level results of the set and clear arithmetic, the mapping of the boundary select values to entries 0 and 63, the granularity patterns for each match mode, and the unchanged exported state after an out-of-window write.

// File: rtl/prb_pkg.sv
package prb_pkg;

    // Stored configuration bits per entry (bits above read as zero)
    localparam int CFG_W = 10;
    // Writable configuration bits: R W X, mode[1:0], lock, user, shared
    localparam logic [CFG_W-1:0] CFG_KEEP = 10'h39F;
    localparam int BIT_LOCK = 7;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } match_mode_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACCESS = 2'b01,
        ST_RESP   = 2'b10
    } acc_state_e;

    function automatic match_mode_e mode_of(input logic [CFG_W-1:0] c);
        return match_mode_e'(c[4:3]);
    endfunction

endpackage

// File: rtl/prb_sel_decode.sv
module prb_sel_decode #(
    parameter int SEL_W       = 12,
    parameter int SEL_BASE    = 256,
    parameter int WIN_SIZE    = 64,
    parameter int NUM_ENTRIES = 64,
    parameter int IDX_W       = 6
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] idx,
    output logic             in_window,
    output logic             hit
);
    localparam logic [SEL_W-1:0] FIRST_V = SEL_W'(SEL_BASE);
    localparam logic [SEL_W-1:0] LAST_V  = SEL_W'(SEL_BASE + WIN_SIZE - 1);
    localparam logic [SEL_W-1:0] COUNT_V = SEL_W'(NUM_ENTRIES);

    logic [SEL_W-1:0] offset;

    always_comb begin
        offset    = sel - FIRST_V;
        in_window = (sel >= FIRST_V) && (sel <= LAST_V);
        idx       = offset[IDX_W-1:0];
        // Window slots past the implemented entries read zero but are legal
        hit       = in_window && (offset < COUNT_V);
    end

endmodule

// File: rtl/prb_entry.sv
module prb_entry
    import prb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GRAN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [ADDR_W-1:0] addr_view
);
    // Low bits forced to zero outside NAPOT, and forced to one inside it
    localparam logic [ADDR_W-1:0] ZERO_MASK = ADDR_W'((64'd1 << GRAN) - 64'd1);
    localparam logic [ADDR_W-1:0] ONE_MASK  = ADDR_W'((64'd1 << (GRAN - 1)) - 64'd1);

    logic [ADDR_W-1:0] addr_raw;
    logic              locked;

    assign locked = cfg_q[BIT_LOCK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            addr_raw <= '0;
        end else begin
            if (cfg_we && !locked) begin
                cfg_q <= cfg_wdata & CFG_KEEP;
            end
            if (addr_we && !locked) begin
                addr_raw <= addr_wdata;
            end
        end
    end

    always_comb begin
        if (mode_of(cfg_q) == MODE_NAPOT) begin
            addr_view = addr_raw | ONE_MASK;
        end else begin
            addr_view = addr_raw & ~ZERO_MASK;
        end
    end

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(cfg_q) && $stable(addr_raw)));                  // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6:5] == 2'b00);                                                // R5

    AST_GRAN_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_of(cfg_q) != MODE_NAPOT) |-> ((addr_view & ZERO_MASK) == '0)); // R7

endmodule

// File: rtl/prb_access_fsm.sv
module prb_access_fsm
    import prb_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_port,
    input  logic [1:0]       req_op,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic             dec_hit,
    input  logic             dec_in_window,
    input  logic [XLEN-1:0]  rd_cfg,
    input  logic [XLEN-1:0]  rd_addr,
    output logic             req_ready,
    output logic [IDX_W-1:0] acc_idx,
    output logic             cfg_we,
    output logic             addr_we,
    output logic [XLEN-1:0]  wr_value,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic             rsp_illegal
);
    acc_state_e       state_q;
    acc_state_e       state_d;
    logic             port_q;
    csr_op_e          op_q;
    logic [XLEN-1:0]  wdata_q;
    logic [XLEN-1:0]  rdata_q;
    logic [XLEN-1:0]  old_val;
    logic [IDX_W-1:0] idx_q;
    logic             hit_q;
    logic             illegal_q;
    logic             accept;
    logic             in_access;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and old-value capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q    <= 1'b0;
            op_q      <= OP_READ;
            wdata_q   <= '0;
            idx_q     <= '0;
            hit_q     <= 1'b0;
            illegal_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                port_q    <= req_port;
                op_q      <= csr_op_e'(req_op);
                wdata_q   <= req_wdata;
                idx_q     <= dec_idx;
                hit_q     <= dec_hit;
                illegal_q <= !dec_in_window;
            end
            if (state_q == ST_ACCESS) begin
                rdata_q <= old_val;
            end
        end
    end

    // Outputs and read-modify-write datapath
    always_comb begin
        in_access = (state_q == ST_ACCESS);
        old_val   = '0;
        if (hit_q) begin
            old_val = port_q ? rd_cfg : rd_addr;
        end
        case (op_q)
            OP_READ:  wr_value = old_val;
            OP_WRITE: wr_value = wdata_q;
            OP_SET:   wr_value = old_val | wdata_q;
            OP_CLEAR: wr_value = old_val & ~wdata_q;
            default:  wr_value = old_val;
        endcase
        cfg_we      = in_access && hit_q && port_q && (op_q != OP_READ);
        addr_we     = in_access && hit_q && !port_q && (op_q != OP_READ);
        acc_idx     = idx_q;
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_RESP);
        rsp_rdata   = rdata_q;
        rsp_illegal = illegal_q;
    end

    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                            // R10

    AST_ACCESS_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |=> rsp_valid);                               // R10

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));                            // R10

    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0));                   // R8

endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank
    import prb_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_ENTRIES = 64,
    parameter int ADDR_W      = 32,
    parameter int GRAN        = 2,
    parameter int SEL_W       = 12,
    parameter int SEL_BASE    = 256,
    parameter int WIN_SIZE    = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_we,
    input  logic [SEL_W-1:0]              sel_wdata,
    output logic [SEL_W-1:0]              sel_q,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_port,
    input  logic [1:0]                    req_op,
    input  logic [XLEN-1:0]               req_wdata,
    output logic                          rsp_valid,
    output logic [XLEN-1:0]               rsp_rdata,
    output logic                          rsp_illegal,
    output logic [NUM_ENTRIES*CFG_W-1:0]  cfg_all,
    output logic [NUM_ENTRIES*ADDR_W-1:0] addr_all
);
    localparam int IDX_W = $clog2(WIN_SIZE);

    logic [IDX_W-1:0]       dec_idx;
    logic                   dec_in_window;
    logic                   dec_hit;
    logic [IDX_W-1:0]       acc_idx;
    logic                   fsm_cfg_we;
    logic                   fsm_addr_we;
    logic [XLEN-1:0]        wr_value;
    logic [XLEN-1:0]        rd_cfg;
    logic [XLEN-1:0]        rd_addr;
    logic [CFG_W-1:0]       cfg_arr  [NUM_ENTRIES];
    logic [ADDR_W-1:0]      addr_arr [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] cfg_we_vec;
    logic [NUM_ENTRIES-1:0] addr_we_vec;

    // Select register; reset value lies outside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

    prb_sel_decode #(
        .SEL_W       (SEL_W),
        .SEL_BASE    (SEL_BASE),
        .WIN_SIZE    (WIN_SIZE),
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_decode (
        .sel       (sel_q),
        .idx       (dec_idx),
        .in_window (dec_in_window),
        .hit       (dec_hit)
    );

    prb_access_fsm #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_port      (req_port),
        .req_op        (req_op),
        .req_wdata     (req_wdata),
        .dec_idx       (dec_idx),
        .dec_hit       (dec_hit),
        .dec_in_window (dec_in_window),
        .rd_cfg        (rd_cfg),
        .rd_addr       (rd_addr),
        .req_ready     (req_ready),
        .acc_idx       (acc_idx),
        .cfg_we        (fsm_cfg_we),
        .addr_we       (fsm_addr_we),
        .wr_value      (wr_value),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_illegal   (rsp_illegal)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        assign cfg_we_vec[g]  = fsm_cfg_we  && (acc_idx == IDX_W'(g));
        assign addr_we_vec[g] = fsm_addr_we && (acc_idx == IDX_W'(g));

        prb_entry #(
            .ADDR_W (ADDR_W),
            .GRAN   (GRAN)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we_vec[g]),
            .cfg_wdata  (wr_value[CFG_W-1:0]),
            .addr_we    (addr_we_vec[g]),
            .addr_wdata (wr_value[ADDR_W-1:0]),
            .cfg_q      (cfg_arr[g]),
            .addr_view  (addr_arr[g])
        );

        assign cfg_all[g*CFG_W +: CFG_W]    = cfg_arr[g];
        assign addr_all[g*ADDR_W +: ADDR_W] = addr_arr[g];
    end

    // Read mux for the entry being accessed
    always_comb begin
        rd_cfg  = '0;
        rd_addr = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (acc_idx == IDX_W'(i)) begin
                rd_cfg  = XLEN'(cfg_arr[i]);
                rd_addr = XLEN'(addr_arr[i]);
            end
        end
    end

    AST_ONE_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_we_vec, addr_we_vec}));                                // R2

endmodule

// File: tb/prot_reg_bank_bench.sv
module prot_reg_bank_bench;
    localparam int N  = 64;
    localparam int CW = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_we = 1'b0;
    logic [11:0]   sel_wdata = '0;
    logic [11:0]   sel_q;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_port = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          rsp_illegal;
    logic [N*CW-1:0] cfg_all;
    logic [N*AW-1:0] addr_all;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    prot_reg_bank u_prot_reg_bank (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
        .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port), .req_op(req_op),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal), .cfg_all(cfg_all), .addr_all(addr_all)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_sel(input logic [11:0] v);
        @(negedge clk);
        sel_we = 1'b1;
        sel_wdata = v;
        @(negedge clk);
        sel_we = 1'b0;
        chk("R2 select readback", 64'(sel_q), 64'(v));
    endtask

    // One alias access; also checks the R10 handshake shape
    task automatic xfer(input logic port, input logic [1:0] op, input logic [63:0] wd,
                        output logic [63:0] rd, output logic ill);
        @(negedge clk);
        req_valid = 1'b1;
        req_port  = port;
        req_op    = op;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", {62'd0, req_ready, rsp_valid}, 64'd0);
        @(negedge clk);
        chk("R10 response valid", 64'(rsp_valid), 64'd1);
        rd  = rsp_rdata;
        ill = rsp_illegal;
        @(negedge clk);
        chk("R10 back to idle", {62'd0, req_ready, rsp_valid}, 64'd2);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cfg zero", 64'(|cfg_all), 64'd0);
        chk("R1 addr zero", 64'(|addr_all), 64'd0);
        chk("R1 ready/valid", {62'd0, req_ready, rsp_valid}, 64'd2);
    endtask

    task automatic t_decode;
        logic [63:0] rd; logic ill;
        set_sel(12'h100);
        xfer(1'b1, 2'b01, 64'h3, rd, ill);
        chk("R8 legal not illegal", 64'(ill), 64'd0);
        chk("R2 entry0 cfg", 64'(cfg_all[0 +: CW]), 64'h3);
        chk("R2 entry1 untouched", 64'(cfg_all[CW +: CW]), 64'h0);
        set_sel(12'h13F);
        xfer(1'b1, 2'b01, 64'h5, rd, ill);
        chk("R11 entry63 cfg export", 64'(cfg_all[63*CW +: CW]), 64'h5);
        xfer(1'b0, 2'b01, 64'h1000, rd, ill);
        chk("R11 entry63 addr export", 64'(addr_all[63*AW +: AW]), 64'h1000);
        xfer(1'b1, 2'b00, 64'h0, rd, ill);
        chk("R3 cfg alias read", rd, 64'h5);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R3 addr alias read", rd, 64'h1000);
    endtask

    task automatic t_ops;
        logic [63:0] rd; logic ill;
        set_sel(12'h103);
        xfer(1'b1, 2'b01, 64'h1, rd, ill);
        chk("R3 write returns old", rd, 64'h0);
        xfer(1'b1, 2'b10, 64'hA, rd, ill);
        chk("R4 set returns old", rd, 64'h1);
        xfer(1'b1, 2'b11, 64'h1, rd, ill);
        chk("R4 clear returns old", rd, 64'hB);
        xfer(1'b1, 2'b00, 64'hFF, rd, ill);
        chk("R4 after clear", rd, 64'hA);
        xfer(1'b1, 2'b00, 64'h0, rd, ill);
        chk("R4 read leaves value", rd, 64'hA);
    endtask

    task automatic t_reserved;
        logic [63:0] rd; logic ill;
        set_sel(12'h102);
        xfer(1'b1, 2'b01, 64'hFFFF_FFFF_FFFF_FF7F, rd, ill);
        xfer(1'b1, 2'b00, 64'h0, rd, ill);
        chk("R5 reserved bits zero", rd, 64'h31F);
    endtask

    task automatic t_width;
        logic [63:0] rd; logic ill;
        set_sel(12'h104);
        xfer(1'b0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R6 R7 all-ones probe", rd, 64'h0000_0000_FFFF_FFFC);
    endtask

    task automatic t_gran;
        logic [63:0] rd; logic ill;
        set_sel(12'h105);
        xfer(1'b0, 2'b01, 64'h1002, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R7 OFF low bits", rd, 64'h1000);
        xfer(1'b1, 2'b01, 64'h08, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R7 TOR low bits", rd, 64'h1000);
        xfer(1'b1, 2'b01, 64'h10, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R7 NA4 low bits", rd, 64'h1000);
        xfer(1'b1, 2'b01, 64'h18, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R7 NAPOT low bits", rd, 64'h1003);
        chk("R11 NAPOT export", 64'(addr_all[5*AW +: AW]), 64'h1003);
    endtask

    task automatic t_illegal;
        logic [63:0] rd; logic ill;
        logic [N*CW-1:0] snap_c;
        logic [N*AW-1:0] snap_a;
        snap_c = cfg_all;
        snap_a = addr_all;
        set_sel(12'h0FF);
        xfer(1'b1, 2'b00, 64'h0, rd, ill);
        chk("R8 below window reads zero", rd, 64'h0);
        chk("R8 below window flag", 64'(ill), 64'd1);
        xfer(1'b1, 2'b01, 64'h7, rd, ill);
        chk("R8 write below window ignored", 64'(cfg_all == snap_c), 64'd1);
        set_sel(12'h140);
        xfer(1'b0, 2'b01, 64'h5555, rd, ill);
        chk("R8 above window flag", 64'(ill), 64'd1);
        chk("R8 write above window ignored", 64'(addr_all == snap_a), 64'd1);
    endtask

    task automatic t_lock;
        logic [63:0] rd; logic ill;
        set_sel(12'h107);
        xfer(1'b0, 2'b01, 64'h40, rd, ill);
        xfer(1'b1, 2'b01, 64'h81, rd, ill);
        xfer(1'b1, 2'b01, 64'h07, rd, ill);
        xfer(1'b1, 2'b11, 64'h80, rd, ill);
        xfer(1'b1, 2'b00, 64'h0, rd, ill);
        chk("R9 locked cfg kept", rd, 64'h81);
        xfer(1'b0, 2'b01, 64'h99, rd, ill);
        xfer(1'b0, 2'b10, 64'h4, rd, ill);
        xfer(1'b0, 2'b00, 64'h0, rd, ill);
        chk("R9 locked addr kept", rd, 64'h40);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_ops();
        t_reserved();
        t_width();
        t_gran();
        t_illegal();
        t_lock();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule